// File: doc/BRIEF.md
# Strip Cluster Peak and Centroid Finder

This block takes one slice of sixteen adjacent readout strips and finds where a particle crossed it. Each strip carries an 8-bit charge in time-to-digital units. The block finds the strip with the largest charge and takes the charges of that strip and its two neighbours. From that three-strip cluster it forms a charge-weighted mean address, which is a dividend (the sum of each address times its charge) over a divisor (the sum of the charges). It then scales the mean by the strip pitch to give a position in micrometres.

The design is a fixed-latency pipeline. The peak search is a comparison tree. The division is a restoring divider unrolled to one quotient bit per pipeline stage, so a new slice can enter on every clock. The peak address travels through a delay line whose depth is derived from the divider length, which keeps it next to the arithmetic result it belongs to. The quotient carries four fractional bits, so the centroid resolves one sixteenth of a strip.

Top module: `strip_centroid_finder`

## Requirements
- R1: The charge of strip i sits at bits [8i+7:8i] of `in_charges`. For every accepted slice, `out_peak_addr` is the address of the strip with the largest charge.
- R2: When several strips share the largest charge, the lowest of their addresses is reported as the peak.
- R3: When the peak is at address 0 or 15, the missing neighbour counts as a charge of zero.
- R4: `out_centroid` equals floor(16·Σ(a·q)/Σq), taken over the peak strip a and the strips a−1 and a+1 only. It has four fractional bits. Charges on all other strips have no effect on it.
- R5: `out_pos_um` equals floor(`out_centroid`·3500/16), which is the centroid times a 3500 µm pitch.
- R6: A slice sampled with `in_valid` high on a rising edge produces `out_valid` high during the cycle after the 11th rising edge, counting the sampling edge as the first. Slices may arrive on consecutive cycles. A cycle with `in_valid` low produces no output.
- R7: A slice accepted with every charge equal to zero produces no output, because its divisor would be zero.
- R8: `out_valid` is low while `rst_n` is low, and it stays low after reset until the first result is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_charges` in this cycle |
| in_charges | input | 128 | Sixteen 8-bit strip charges, strip 0 in the low byte |
| out_valid | output | 1 | A result is present on the outputs below |
| out_peak_addr | output | 4 | Address of the peak strip |
| out_centroid | output | 8 | Weighted mean address, 4 integer and 4 fractional bits |
| out_pos_um | output | 16 | Position in micrometres from strip 0 |

## Verification
No state survives from one slice to the next, so any wrong internal value affects only the one result that passes through it. That result appears exactly eleven edges after the slice was sampled. A wrong comparison in the peak tree shows at the ports as a peak address off by one or more strips, and the centroid moves with it. A wrong partial remainder in the divider corrupts the quotient bit of its own stage and every lower bit, and the position follows that error. A broken valid chain shows as a pulse one cycle early or late, or as a pulse produced by an all-zero slice.

// File: rtl/scf_pkg.sv
package scf_pkg;

   localparam int unsigned DEF_STRIPS   = 16;
   localparam int unsigned DEF_CHG_W    = 8;
   localparam int unsigned DEF_FRAC_W   = 4;
   localparam int unsigned DEF_PITCH_UM = 3500;

   // Smallest number of bits that can hold the value v (at least one).
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned b;
      b = 1;
      while ((b < 32) && ((v >> b) != 0)) b++;
      return b;
   endfunction

endpackage

// File: rtl/scf_peak_search.sv
module scf_peak_search #(
   parameter int unsigned N_STRIPS = 16,
   parameter int unsigned CHG_W    = 8,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [N_STRIPS*CHG_W-1:0] in_charges,
   output logic                      pk_valid,
   output logic [ADDR_W-1:0]         pk_addr,
   output logic [CHG_W-1:0]          pk_q_lo,
   output logic [CHG_W-1:0]          pk_q_mid,
   output logic [CHG_W-1:0]          pk_q_hi
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_STRIPS - 1);

   logic [CHG_W-1:0]  ch      [N_STRIPS];
   logic [CHG_W-1:0]  tree_q  [N_STRIPS];
   logic [ADDR_W-1:0] tree_a  [N_STRIPS];
   logic [ADDR_W-1:0] win_a;
   logic [CHG_W-1:0]  nb_lo, nb_hi;

   genvar gi;
   generate
      for (gi = 0; gi < N_STRIPS; gi++) begin : g_unpack
         assign ch[gi] = in_charges[gi*CHG_W +: CHG_W];
      end
   endgenerate

   // Pairwise tournament; the lower-address entrant keeps its place on a tie.
   always_comb begin
      for (int i = 0; i < N_STRIPS; i++) begin
         tree_q[i] = ch[i];
         tree_a[i] = ADDR_W'(i);
      end
      for (int s = 1; s < N_STRIPS; s = s * 2) begin
         for (int i = 0; i + s < N_STRIPS; i = i + 2 * s) begin
            if (tree_q[i+s] > tree_q[i]) begin
               tree_q[i] = tree_q[i+s];
               tree_a[i] = tree_a[i+s];
            end
         end
      end
   end

   assign win_a = tree_a[0];
   assign nb_lo = (win_a == '0)        ? '0 : ch[win_a - 1'b1];
   assign nb_hi = (win_a == LAST_ADDR) ? '0 : ch[win_a + 1'b1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pk_valid <= 1'b0;
         pk_addr  <= '0;
         pk_q_lo  <= '0;
         pk_q_mid <= '0;
         pk_q_hi  <= '0;
      end else begin
         pk_valid <= in_valid;
         pk_addr  <= win_a;
         pk_q_lo  <= nb_lo;
         pk_q_mid <= tree_q[0];
         pk_q_hi  <= nb_hi;
      end
   end

endmodule

// File: rtl/scf_cluster_sum.sv
module scf_cluster_sum #(
   parameter int unsigned CHG_W  = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DEN_W  = 10,
   parameter int unsigned DVD_W  = 14
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CHG_W-1:0]  q_lo,
   input  logic [CHG_W-1:0]  q_mid,
   input  logic [CHG_W-1:0]  q_hi,
   output logic [DVD_W-1:0]  dividend,
   output logic [DEN_W-1:0]  divisor
);

   logic [DVD_W-1:0] a_mid, a_lo, a_hi;

   // Edge neighbours arrive as zero charge, so a wrapped address weight is harmless.
   assign a_mid = DVD_W'(addr);
   assign a_lo  = a_mid - 1'b1;
   assign a_hi  = a_mid + 1'b1;

   assign divisor  = DEN_W'(q_lo) + DEN_W'(q_mid) + DEN_W'(q_hi);
   assign dividend = a_lo * DVD_W'(q_lo) + a_mid * DVD_W'(q_mid) + a_hi * DVD_W'(q_hi);

endmodule

// File: rtl/scf_restoring_div.sv
module scf_restoring_div #(
   parameter int unsigned NUM_W = 18,
   parameter int unsigned DEN_W = 10,
   parameter int unsigned Q_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [NUM_W-1:0] ld_num,
   input  logic [DEN_W-1:0] ld_den,
   output logic             quo_valid,
   output logic [Q_W-1:0]   quo
);

   // Caller guarantees num < den * 2**Q_W, so the top slice of the
   // numerator is already a valid partial remainder.
   logic [Q_W:0]     v_q;
   logic [DEN_W-1:0] rem_q  [Q_W+1];
   logic [DEN_W-1:0] den_q  [Q_W+1];
   logic [Q_W-1:0]   low_q  [Q_W+1];
   logic [Q_W-1:0]   quo_q  [Q_W+1];
   logic [DEN_W:0]   trial  [Q_W];
   logic [DEN_W-1:0] rem_nx [Q_W];
   logic             bit_nx [Q_W];

   always_comb begin
      for (int k = 0; k < Q_W; k++) begin
         trial[k] = {rem_q[k], low_q[k][Q_W-1-k]};
         if (trial[k] >= {1'b0, den_q[k]}) begin
            bit_nx[k] = 1'b1;
            rem_nx[k] = DEN_W'(trial[k] - {1'b0, den_q[k]});
         end else begin
            bit_nx[k] = 1'b0;
            rem_nx[k] = trial[k][DEN_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int k = 0; k <= Q_W; k++) begin
            rem_q[k] <= '0;
            den_q[k] <= '0;
            low_q[k] <= '0;
            quo_q[k] <= '0;
         end
      end else begin
         v_q[0]   <= ld_valid;
         rem_q[0] <= DEN_W'(ld_num >> Q_W);
         den_q[0] <= ld_den;
         low_q[0] <= ld_num[Q_W-1:0];
         quo_q[0] <= '0;
         for (int k = 0; k < Q_W; k++) begin
            v_q[k+1]   <= v_q[k];
            rem_q[k+1] <= rem_nx[k];
            den_q[k+1] <= den_q[k];
            low_q[k+1] <= low_q[k];
            quo_q[k+1] <= {quo_q[k][Q_W-2:0], bit_nx[k]};
         end
      end
   end

   assign quo_valid = v_q[Q_W];
   assign quo       = quo_q[Q_W];

endmodule

// File: rtl/scf_delay_line.sv
module scf_delay_line #(
   parameter int unsigned W     = 4,
   parameter int unsigned DEPTH = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] sr [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
            end else begin
               sr[0] <= d;
               for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
            end
         end
         assign q = sr[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/strip_centroid_finder.sv
module strip_centroid_finder #(
   parameter int unsigned N_STRIPS = scf_pkg::DEF_STRIPS,
   parameter int unsigned CHG_W    = scf_pkg::DEF_CHG_W,
   parameter int unsigned FRAC_W   = scf_pkg::DEF_FRAC_W,
   parameter int unsigned PITCH_UM = scf_pkg::DEF_PITCH_UM,
   localparam int unsigned ADDR_W  = $clog2(N_STRIPS),
   localparam int unsigned Q_W     = ADDR_W + FRAC_W,
   localparam int unsigned POS_W   = scf_pkg::bits_for((N_STRIPS - 1) * PITCH_UM)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [N_STRIPS*CHG_W-1:0] in_charges,
   output logic                      out_valid,
   output logic [ADDR_W-1:0]         out_peak_addr,
   output logic [Q_W-1:0]            out_centroid,
   output logic [POS_W-1:0]          out_pos_um
);

   localparam int unsigned Q_MAX   = (1 << CHG_W) - 1;
   localparam int unsigned DEN_W   = scf_pkg::bits_for(3 * Q_MAX);
   localparam int unsigned DVD_W   = scf_pkg::bits_for(3 * (N_STRIPS - 1) * Q_MAX);
   localparam int unsigned NUM_W   = DVD_W + FRAC_W;
   localparam int unsigned PITCH_W = scf_pkg::bits_for(PITCH_UM);
   localparam int unsigned PROD_W  = Q_W + PITCH_W;
   localparam int unsigned ADDR_DLY = Q_W + 2;
   localparam int unsigned LAT     = Q_W + 3;

   initial begin
      assert (N_STRIPS >= 4 && (1 << ADDR_W) == N_STRIPS)
         else $error("strip count must be a power of two, at least 4");
      assert (CHG_W >= 1 && CHG_W <= 16) else $error("charge width out of range");
      assert (FRAC_W >= 1 && FRAC_W <= 12) else $error("fraction width out of range");
      assert (PITCH_UM >= 1) else $error("pitch must be positive");
      assert (LAT == ADDR_DLY + 1) else $error("address delay misaligned");
   end

   logic              pk_valid;
   logic [ADDR_W-1:0] pk_addr;
   logic [CHG_W-1:0]  pk_q_lo, pk_q_mid, pk_q_hi;
   logic [DVD_W-1:0]  dividend;
   logic [DEN_W-1:0]  divisor;
   logic              quo_valid;
   logic [Q_W-1:0]    quo;
   logic [ADDR_W-1:0] addr_dly;
   logic [PROD_W-1:0] prod;

   scf_peak_search #(.N_STRIPS(N_STRIPS), .CHG_W(CHG_W), .ADDR_W(ADDR_W)) u_peak (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_charges (in_charges),
      .pk_valid   (pk_valid),
      .pk_addr    (pk_addr),
      .pk_q_lo    (pk_q_lo),
      .pk_q_mid   (pk_q_mid),
      .pk_q_hi    (pk_q_hi)
   );

   scf_cluster_sum #(.CHG_W(CHG_W), .ADDR_W(ADDR_W), .DEN_W(DEN_W), .DVD_W(DVD_W)) u_sum (
      .addr     (pk_addr),
      .q_lo     (pk_q_lo),
      .q_mid    (pk_q_mid),
      .q_hi     (pk_q_hi),
      .dividend (dividend),
      .divisor  (divisor)
   );

   scf_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(Q_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_valid  (pk_valid && (divisor != '0)),
      .ld_num    (NUM_W'(dividend) << FRAC_W),
      .ld_den    (divisor),
      .quo_valid (quo_valid),
      .quo       (quo)
   );

   scf_delay_line #(.W(ADDR_W), .DEPTH(ADDR_DLY)) u_addr_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pk_addr),
      .q     (addr_dly)
   );

   assign prod = PROD_W'(quo) * PROD_W'(PITCH_UM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_centroid <= '0;
         out_pos_um   <= '0;
      end else begin
         out_valid    <= quo_valid;
         out_centroid <= quo;
         out_pos_um   <= POS_W'(prod >> FRAC_W);
      end
   end

   assign out_peak_addr = addr_dly;

endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
   parameter int unsigned N_STRIPS = 16,
   parameter int unsigned CHG_W    = 8,
   parameter int unsigned FRAC_W   = 4,
   parameter int unsigned PITCH_UM = 3500,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned Q_W      = 8,
   parameter int unsigned POS_W    = 16,
   parameter int unsigned LAT      = 11
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [N_STRIPS*CHG_W-1:0] in_charges,
   input logic                      out_valid,
   input logic [ADDR_W-1:0]         out_peak_addr,
   input logic [Q_W-1:0]            out_centroid,
   input logic [POS_W-1:0]          out_pos_um
);

   localparam int ONE = 1 << FRAC_W;
   localparam int POS_LIMIT = (N_STRIPS - 1) * PITCH_UM;

   logic [LAT-1:0] due_q;

   always_ff @(posedge clk) begin
      if (!rst_n) due_q <= '0;
      else        due_q <= {due_q[LAT-2:0], in_valid && (in_charges != '0)};
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == due_q[LAT-1]); // R6

   AST_NO_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !due_q[LAT-1] |-> !out_valid); // R7

   AST_CENTROID_NEAR_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_centroid) >= (int'(out_peak_addr) - 1) * ONE)
                 && (int'(out_centroid) <= (int'(out_peak_addr) + 1) * ONE)); // R4

   AST_LOW_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_peak_addr == '0) |-> int'(out_centroid) <= ONE); // R3

   AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> int'(out_pos_um) <= POS_LIMIT); // R5

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid); // R8

endmodule

bind strip_centroid_finder scf_checker #(
   .N_STRIPS (N_STRIPS),
   .CHG_W    (CHG_W),
   .FRAC_W   (FRAC_W),
   .PITCH_UM (PITCH_UM),
   .ADDR_W   (ADDR_W),
   .Q_W      (Q_W),
   .POS_W    (POS_W),
   .LAT      (LAT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_charges    (in_charges),
   .out_valid     (out_valid),
   .out_peak_addr (out_peak_addr),
   .out_centroid  (out_centroid),
   .out_pos_um    (out_pos_um)
);

// File: tb/strip_centroid_finder_test.sv
`timescale 1ns/1ps
module strip_centroid_finder_test;

   localparam int NS  = 16;
   localparam int LAT = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_charges = '0;
   logic         out_valid;
   logic [3:0]   out_peak_addr;
   logic [7:0]   out_centroid;
   logic [15:0]  out_pos_um;

   int n_chk = 0;
   int n_bad = 0;
   int n_edges = 0;
   bit done = 0;
   logic [31:0] lfsr = 32'h1D2C_3B4A;

   bit    s_chk [32];
   bit    s_v   [32];
   int    s_a   [32];
   int    s_c   [32];
   int    s_p   [32];
   string s_tag [32];

   strip_centroid_finder uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_charges    (in_charges),
      .out_valid     (out_valid),
      .out_peak_addr (out_peak_addr),
      .out_centroid  (out_centroid),
      .out_pos_um    (out_pos_um)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) n_edges <= n_edges + 1;

   task automatic cmp(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference: linear scan (first strict maximum), three-strip weighted mean.
   task automatic model(input logic [127:0] ch, output bit ok, output int a,
                        output int c, output int p);
      int best, lo, mid, hi, den, dvd;
      best = -1; a = 0;
      for (int i = 0; i < NS; i++)
         if (int'(ch[i*8 +: 8]) > best) begin best = int'(ch[i*8 +: 8]); a = i; end
      mid = best;
      lo  = (a > 0)      ? int'(ch[(a-1)*8 +: 8]) : 0;
      hi  = (a < NS - 1) ? int'(ch[(a+1)*8 +: 8]) : 0;
      den = lo + mid + hi;
      dvd = (a - 1) * lo + a * mid + (a + 1) * hi;
      ok  = (den != 0);
      c   = ok ? (dvd * 16) / den : 0;
      p   = (c * 3500) / 16;
   endtask

   task automatic check_slot();
      int s;
      s = n_edges % 32;
      if (s_chk[s] || out_valid) begin
         cmp({"R6/", s_tag[s]}, "out_valid", int'(out_valid), int'(s_v[s]));
         if (s_v[s] && out_valid) begin
            cmp({"R1/", s_tag[s]}, "peak address", int'(out_peak_addr), s_a[s]);
            cmp({"R4/", s_tag[s]}, "centroid", int'(out_centroid), s_c[s]);
            cmp({"R5/", s_tag[s]}, "position", int'(out_pos_um), s_p[s]);
         end
      end
      s_chk[s] = 0;
      s_v[s]   = 0;
   endtask

   task automatic step(input logic v, input logic [127:0] ch, input string tag);
      int s, a, c, p;
      bit ok;
      @(negedge clk);
      check_slot();
      in_valid   = v;
      in_charges = ch;
      model(ch, ok, a, c, p);
      s = (n_edges + LAT) % 32;
      s_chk[s] = 1;
      s_v[s]   = v && ok;
      s_a[s]   = a;
      s_c[s]   = c;
      s_p[s]   = p;
      s_tag[s] = tag;
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] x);
      return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL R6 watchdog: actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] ch;
      int lvl [6] = '{0, 44, 88, 132, 176, 220};

      // R8: quiet during reset
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         cmp("R8", "out_valid in reset", int'(out_valid), 0);
      end
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         cmp("R8", "out_valid after reset", int'(out_valid), 0);
      end

      // R1 R3 R4: single isolated strip at every address, edges included
      for (int a = 0; a < NS; a++) begin
         ch = '0;
         ch[a*8 +: 8] = 8'(a * 9 + 17);
         step(1'b1, ch, "R3 single strip");
      end

      // R1 R2 R3 R4: peak of 220 at each address, neighbour grid, background noise
      for (int p = 0; p < NS; p++)
         for (int li = 0; li < 6; li++)
            for (int ri = 0; ri < 6; ri++) begin
               ch = '0;
               for (int i = 0; i < NS; i++) ch[i*8 +: 8] = 8'((i * 13 + p * 5) % 31);
               ch[p*8 +: 8] = 8'd220;
               if (p > 0)      ch[(p-1)*8 +: 8] = 8'(lvl[li]);
               if (p < NS - 1) ch[(p+1)*8 +: 8] = 8'(lvl[ri]);
               step(1'b1, ch, "R2 grid");
            end

      // R2: distant ties and a flat slice
      ch = '0; ch[5*8 +: 8] = 8'd255; ch[11*8 +: 8] = 8'd255; ch[12*8 +: 8] = 8'd90;
      step(1'b1, ch, "R2 far tie");
      ch = '0; for (int i = 0; i < NS; i++) ch[i*8 +: 8] = 8'd77;
      step(1'b1, ch, "R2 flat");
      ch = '0; ch[15*8 +: 8] = 8'd255; ch[14*8 +: 8] = 8'd255;
      step(1'b1, ch, "R3 top edge tie");

      // R7: all-zero slices, back to back and mixed with data
      step(1'b1, '0, "R7 zero");
      step(1'b1, '0, "R7 zero");
      ch = '0; ch[7*8 +: 8] = 8'd3;
      step(1'b1, ch, "R7 neighbour of zero");
      step(1'b1, '0, "R7 zero");

      // R6: random slices with in_valid toggling; invalid ones must vanish
      for (int k = 0; k < 400; k++) begin
         for (int w = 0; w < 4; w++) begin
            lfsr = nxt(lfsr); lfsr = nxt(lfsr); lfsr = nxt(lfsr);
            ch[w*32 +: 32] = lfsr ^ {lfsr[15:0], lfsr[31:16]};
         end
         lfsr = nxt(lfsr);
         step(lfsr[0] | lfsr[3], ch, "R6 random");
      end

      // drain
      for (int k = 0; k < LAT + 4; k++) step(1'b0, '0, "R6 drain");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule